// File: doc/BRIEF.md
# Twenty-Bit Instruction Field Decoder

This block takes one 20-bit instruction word and splits it into the fields that an execution stage needs. It first sorts the word into one of nine classes, or flags it as illegal. It then sets out the operation code, target and index register codes, byte flag, a variant flag, a 20-bit two's complement displacement and the shift parameters. The word is read as a 2-bit class prefix (bits 19:18) followed by six 3-bit fields. In the memory-reference forms these fields hold an opcode (17:15), a target register (14:13), a byte bit (12), an index register (11:10), a sign bit (9) and a 9-bit magnitude (8:0).

Words enter on a valid/ready stream and leave one register stage later on a second valid/ready stream. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. The block raises `in_ready` whenever its output stage is empty or is being drained in the same cycle. A result that is offered but not taken stays frozen until the consumer raises `out_ready`. Because of this, back-pressure passes straight through the single stage with no bubble. The block does no execution, sequencing or memory access.

Top module: `instr_decoder`

## Requirements
- R1: Class codes on `out_class`: 0 memory-operate, 1 store, 2 jump, 3 branch, 4 set-on-condition, 5 halt, 6 interrupt control, 7 effective-address load, 8 shift, 9 illegal. A word with prefix 1x whose opcode (17:15) is 0-3 or 5 is memory-operate. It reports `out_op`=opcode, `out_indexed`=bit 18, `out_target`=bits 14:13, `out_byte`=bit 12, `out_index`=bits 11:10 and the displacement. Every field that a class does not list reads zero.
- R2: For memory-operate, store, jump and effective-address load, `out_disp` is the magnitude in bits 8:0, negated in two's complement when bit 9 is set. A negative zero gives 0.
- R3: Prefix 11 with opcode 11o and a nonzero target is a store. It reports `out_op`, `out_indexed`=1, target, index, byte, `out_flag`=o and the displacement.
- R4: Prefix 1x with opcode 11o, target 00 and byte bit 0 is a jump, with `out_flag`=o (1 means subroutine call). It reports `out_op`, `out_indexed`=bit 18, index and the displacement, and target 0.
- R5: Prefix 00 with bits 14:13 zero and a condition (17:15) of 0-4 or 6 is a branch, unless it is the halt word. It reports `out_op`=condition and `out_flag`=bit 12. `out_disp` is twice the 11-bit magnitude in bits 10:0, negated when bit 11 is set.
- R6: Prefix 01 under the same field rules as R5 is a set-on-condition, with the same condition, flag and displacement outputs.
- R7: Exactly the word 0x30000 is a halt, with `out_op`=6.
- R8: Words 0x39000 and 0x39400 are interrupt control. `out_flag`=bit 10 (1 enables) and `out_op`=7.
- R9: Prefix 10, opcode 110, byte bit 0 and a nonzero target is an effective-address load. It reports `out_op`, target, index and the displacement, with `out_indexed`=0.
- R10: Prefix 10, opcode 11L and byte bit 1 is a shift, provided bits 9:5 are zero and the count in bits 4:0 is from 1 to 20. It reports `out_op`, target, `out_flag`=L, `out_shift_mode`=bits 11:10 and `out_shift_cnt`=count.
- R11: Every other word is illegal: `out_class`=9, `out_illegal`=1 and all other fields zero. `out_illegal` is 0 for every legal word.
- R12: A word is accepted on an edge with `in_valid` and `in_ready` high. `in_ready` is high whenever `out_valid` is low or `out_ready` is high. Its result appears with `out_valid` one cycle after acceptance and holds unchanged while `out_ready` is low.
- R13: While `rst_n` is low and right after it rises, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | 20 | Instruction word |
| out_valid | output | 1 | Decoded result offered |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_class | output | 4 | Class code (R1) |
| out_illegal | output | 1 | Word matched no legal form |
| out_op | output | 3 | Opcode or condition field |
| out_indexed | output | 1 | Indexed addressing mode |
| out_target | output | 2 | Target register code |
| out_index | output | 2 | Index register code |
| out_byte | output | 1 | Byte access flag |
| out_flag | output | 1 | Class variant bit (call, enable, shift direction, store variant, condition qualifier) |
| out_disp | output | 20 | Signed displacement |
| out_shift_cnt | output | 5 | Shift count |
| out_shift_mode | output | 2 | Shift mode bits |

## Verification
Every decoded field is due on the first clock edge after the word is accepted. The model therefore holds a queue of expected results: an entry is pushed when an acceptance is seen and compared when a transfer is seen. The queue can never hold more than one entry. In each cycle the checks sample in the low clock phase, after the inputs for that cycle are settled. They confirm that `out_valid` matches whether an entry is pending. While the consumer stalls, they re-compare the held result to the same expected entry on every cycle.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int WORD_W    = 20;
  localparam int DISP_W    = 20;
  localparam int MEM_MAG_W = 9;
  localparam int BR_MAG_W  = 11;
  localparam int SH_W      = 5;
  localparam int SHIFT_MAX = 20;
  localparam int CLS_W     = 4;

  typedef enum logic [CLS_W-1:0] {
    CL_MEM    = 4'd0,
    CL_STORE  = 4'd1,
    CL_JUMP   = 4'd2,
    CL_BRANCH = 4'd3,
    CL_SETCC  = 4'd4,
    CL_HALT   = 4'd5,
    CL_INTR   = 4'd6,
    CL_LEA    = 4'd7,
    CL_SHIFT  = 4'd8,
    CL_BAD    = 4'd9
  } cls_e;

  typedef struct packed {
    logic [CLS_W-1:0]  cls;
    logic              illegal;
    logic [2:0]        op;
    logic              indexed;
    logic [1:0]        target;
    logic [1:0]        index;
    logic              byte_sel;
    logic              flag;
    logic [DISP_W-1:0] disp;
    logic [SH_W-1:0]   shcnt;
    logic [1:0]        shmode;
  } dec_t;
endpackage

// File: rtl/dec_disp.sv
module dec_disp #(
  parameter int MAG_W = 9,
  parameter int SCALE = 0,
  parameter int OUT_W = 20
) (
  input  logic             sign,
  input  logic [MAG_W-1:0] mag,
  output logic [OUT_W-1:0] value
);
  localparam int PAD_W = OUT_W - MAG_W;

  logic [OUT_W-1:0] zext;
  logic [OUT_W-1:0] scaled;

  assign zext = {{PAD_W{1'b0}}, mag};

  generate
    if (SCALE == 0) begin : g_plain
      assign scaled = zext;
    end else begin : g_scaled
      assign scaled = {zext[OUT_W-1-SCALE:0], {SCALE{1'b0}}};
    end
  endgenerate

  assign value = sign ? (~scaled + 1'b1) : scaled;
endmodule

// File: rtl/dec_fields.sv
module dec_fields
  import dec_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dec_t              dec
);
  logic [1:0]        pre;
  logic [2:0]        opf;
  logic [1:0]        tgt;
  logic              bsel;
  logic [1:0]        idx;
  logic [SH_W-1:0]   cnt;
  logic              cnt_ok;
  logic              cond_ok;
  logic [DISP_W-1:0] mem_disp;
  logic [DISP_W-1:0] br_disp;
  logic              ok;

  assign pre  = word[19:18];
  assign opf  = word[17:15];
  assign tgt  = word[14:13];
  assign bsel = word[12];
  assign idx  = word[11:10];
  assign cnt  = word[SH_W-1:0];

  assign cnt_ok  = (cnt >= SH_W'(1)) && (cnt <= SH_W'(SHIFT_MAX)) && (word[9:5] == 5'd0);
  assign cond_ok = (opf != 3'd5) && (opf != 3'd7) && (tgt == 2'b00);

  dec_disp #(.MAG_W(MEM_MAG_W), .SCALE(0), .OUT_W(DISP_W)) u_mem_disp (
    .sign  (word[MEM_MAG_W]),
    .mag   (word[MEM_MAG_W-1:0]),
    .value (mem_disp)
  );

  dec_disp #(.MAG_W(BR_MAG_W), .SCALE(1), .OUT_W(DISP_W)) u_br_disp (
    .sign  (word[BR_MAG_W]),
    .mag   (word[BR_MAG_W-1:0]),
    .value (br_disp)
  );

  always_comb begin
    dec = '0;
    ok  = 1'b0;
    unique case (pre)
      2'b00: begin
        if (opf == 3'd6 && word[14:0] == 15'd0) begin
          dec.cls = CL_HALT;
          ok      = 1'b1;
        end else if (opf == 3'd7) begin
          if (word[14:12] == 3'b001 && !word[11] && word[9:0] == 10'd0) begin
            dec.cls  = CL_INTR;
            dec.flag = word[10];
            ok       = 1'b1;
          end
        end else if (cond_ok) begin
          dec.cls  = CL_BRANCH;
          dec.flag = bsel;
          dec.disp = br_disp;
          ok       = 1'b1;
        end
      end
      2'b01: begin
        if (cond_ok) begin
          dec.cls  = CL_SETCC;
          dec.flag = bsel;
          dec.disp = br_disp;
          ok       = 1'b1;
        end
      end
      default: begin
        if (opf[2:1] == 2'b11) begin
          if (tgt == 2'b00 && !bsel) begin
            dec.cls     = CL_JUMP;
            dec.indexed = pre[0];
            dec.index   = idx;
            dec.flag    = opf[0];
            dec.disp    = mem_disp;
            ok          = 1'b1;
          end else if (pre[0]) begin
            if (tgt != 2'b00) begin
              dec.cls      = CL_STORE;
              dec.indexed  = 1'b1;
              dec.target   = tgt;
              dec.index    = idx;
              dec.byte_sel = bsel;
              dec.flag     = opf[0];
              dec.disp     = mem_disp;
              ok           = 1'b1;
            end
          end else if (bsel) begin
            if (cnt_ok) begin
              dec.cls    = CL_SHIFT;
              dec.target = tgt;
              dec.flag   = opf[0];
              dec.shmode = idx;
              dec.shcnt  = cnt;
              ok         = 1'b1;
            end
          end else if (!opf[0]) begin
            dec.cls    = CL_LEA;
            dec.target = tgt;
            dec.index  = idx;
            dec.disp   = mem_disp;
            ok         = 1'b1;
          end
        end else if (opf != 3'd4) begin
          dec.cls      = CL_MEM;
          dec.indexed  = pre[0];
          dec.target   = tgt;
          dec.index    = idx;
          dec.byte_sel = bsel;
          dec.disp     = mem_disp;
          ok           = 1'b1;
        end
      end
    endcase

    if (ok) begin
      dec.op = opf;
    end else begin
      dec         = '0;
      dec.cls     = CL_BAD;
      dec.illegal = 1'b1;
    end
  end
endmodule

// File: rtl/dec_slice.sv
module dec_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CLS_W-1:0]  out_class,
  output logic              out_illegal,
  output logic [2:0]        out_op,
  output logic              out_indexed,
  output logic [1:0]        out_target,
  output logic [1:0]        out_index,
  output logic              out_byte,
  output logic              out_flag,
  output logic [DISP_W-1:0] out_disp,
  output logic [SH_W-1:0]   out_shift_cnt,
  output logic [1:0]        out_shift_mode
);
  localparam int REC_W = $bits(dec_t);

  dec_t comb_rec;
  dec_t held_rec;

  dec_fields u_fields (
    .word (in_word),
    .dec  (comb_rec)
  );

  dec_slice #(.W(REC_W)) u_slice (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (comb_rec),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (held_rec)
  );

  assign out_class      = held_rec.cls;
  assign out_illegal    = held_rec.illegal;
  assign out_op         = held_rec.op;
  assign out_indexed    = held_rec.indexed;
  assign out_target     = held_rec.target;
  assign out_index      = held_rec.index;
  assign out_byte       = held_rec.byte_sel;
  assign out_flag       = held_rec.flag;
  assign out_disp       = held_rec.disp;
  assign out_shift_cnt  = held_rec.shcnt;
  assign out_shift_mode = held_rec.shmode;
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk
  import dec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CLS_W-1:0]  out_class,
  input logic              out_illegal,
  input logic [2:0]        out_op,
  input logic [1:0]        out_target,
  input logic              out_flag,
  input logic [DISP_W-1:0] out_disp,
  input logic [SH_W-1:0]   out_shift_cnt
);
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_class) && $stable(out_disp) && $stable(out_op)); // R12
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R12
  AST_OUTPUT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid)); // R12
  AST_ILLEGAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_class == CL_BAD && out_disp == '0 && out_op == 3'd0 && out_target == 2'd0); // R11
  AST_SHIFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == CL_SHIFT |-> out_shift_cnt >= SH_W'(1) && out_shift_cnt <= SH_W'(SHIFT_MAX)); // R10
  AST_JUMP_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == CL_JUMP |-> out_target == 2'd0); // R4
  AST_HALT_BARE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == CL_HALT |-> out_disp == '0 && !out_flag && out_op == 3'd6); // R7
  AST_NO_BAD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal |-> out_class != CL_BAD); // R11
endmodule

bind instr_decoder instr_decoder_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_class     (out_class),
  .out_illegal   (out_illegal),
  .out_op        (out_op),
  .out_target    (out_target),
  .out_flag      (out_flag),
  .out_disp      (out_disp),
  .out_shift_cnt (out_shift_cnt)
);

// File: tb/instr_decoder_bench.sv
module instr_decoder_bench;
  import dec_pkg::*;

  localparam int N_DIR = 24;
  localparam int N_RND = 600;
  localparam int N_TOT = N_DIR + N_RND;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [19:0] in_word;
  logic        out_valid;
  logic        out_ready;
  logic [3:0]  out_class;
  logic        out_illegal;
  logic [2:0]  out_op;
  logic        out_indexed;
  logic [1:0]  out_target;
  logic [1:0]  out_index;
  logic        out_byte;
  logic        out_flag;
  logic [19:0] out_disp;
  logic [4:0]  out_shift_cnt;
  logic [1:0]  out_shift_mode;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  instr_decoder u_instr_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class), .out_illegal(out_illegal),
    .out_op(out_op), .out_indexed(out_indexed), .out_target(out_target), .out_index(out_index),
    .out_byte(out_byte), .out_flag(out_flag), .out_disp(out_disp), .out_shift_cnt(out_shift_cnt),
    .out_shift_mode(out_shift_mode)
  );

  function automatic logic [19:0] mk(input logic [1:0] p, input logic [2:0] o, input logic [2:0] f1,
                                     input logic [2:0] f2, input logic [8:0] lo);
    return {p, o, f1, f2, lo};
  endfunction

  function automatic logic [19:0] sdisp(input logic s, input int mag);
    int v;
    v = s ? -mag : mag;
    return v[19:0];
  endfunction

  function automatic dec_t ref_dec(input logic [19:0] w);
    dec_t e;
    logic [1:0] p; logic [2:0] o; logic [1:0] a; logic b; logic [1:0] x;
    p = w[19:18]; o = w[17:15]; a = w[14:13]; b = w[12]; x = w[11:10];
    e = '0;
    e.cls = CL_BAD;
    if (w == 20'h30000) e.cls = CL_HALT;                          // R7
    else if (w == 20'h39000 || w == 20'h39400) begin              // R8
      e.cls = CL_INTR; e.flag = w[10];
    end else if (!p[1]) begin                                     // R5 R6
      if (o inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd6} && a == 2'd0) begin
        e.cls  = p[0] ? CL_SETCC : CL_BRANCH;
        e.flag = b;
        e.disp = sdisp(w[11], 2 * int'(w[10:0]));
      end
    end else if (o == 3'd6 || o == 3'd7) begin
      if (a == 2'd0 && !b) begin                                  // R4
        e.cls = CL_JUMP; e.indexed = p[0]; e.index = x; e.flag = o[0];
        e.disp = sdisp(w[9], int'(w[8:0]));
      end else if (p == 2'b11) begin                              // R3
        if (a != 2'd0) begin
          e.cls = CL_STORE; e.indexed = 1'b1; e.target = a; e.index = x;
          e.byte_sel = b; e.flag = o[0]; e.disp = sdisp(w[9], int'(w[8:0]));
        end
      end else if (b) begin                                       // R10
        if (w[9:5] == 5'd0 && w[4:0] >= 5'd1 && w[4:0] <= 5'd20) begin
          e.cls = CL_SHIFT; e.target = a; e.flag = o[0]; e.shmode = x; e.shcnt = w[4:0];
        end
      end else if (o == 3'd6) begin                               // R9
        e.cls = CL_LEA; e.target = a; e.index = x; e.disp = sdisp(w[9], int'(w[8:0]));
      end
    end else if (o != 3'd4) begin                                 // R1 R2
      e.cls = CL_MEM; e.indexed = p[0]; e.target = a; e.index = x; e.byte_sel = b;
      e.disp = sdisp(w[9], int'(w[8:0]));
    end
    if (e.cls == CL_BAD) e.illegal = 1'b1;                        // R11
    else e.op = o;
    return e;
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      CL_MEM:    return "R1 R2";
      CL_STORE:  return "R3";
      CL_JUMP:   return "R4";
      CL_BRANCH: return "R5";
      CL_SETCC:  return "R6";
      CL_HALT:   return "R7";
      CL_INTR:   return "R8";
      CL_LEA:    return "R9";
      CL_SHIFT:  return "R10";
      default:   return "R11";
    endcase
  endfunction

  function automatic logic [19:0] gen(input int k);
    logic [19:0] r;
    r = 20'($urandom);
    case (k)
      0:  return 20'h30000;                                  // halt
      1:  return 20'h30001;                                  // always-branch, disp +2
      2:  return 20'h39000;                                  // interrupt disable
      3:  return 20'h39400;                                  // interrupt enable
      4:  return 20'h39800;                                  // malformed interrupt
      5:  return mk(2'b10, 3'd6, 3'b011, 3'b000, 9'd0);      // shift count 0
      6:  return mk(2'b10, 3'd6, 3'b011, 3'b000, 9'd1);      // shift count 1
      7:  return mk(2'b10, 3'd7, 3'b011, 3'b110, 9'd20);     // shift count 20
      8:  return mk(2'b10, 3'd6, 3'b011, 3'b000, 9'd21);     // shift count 21
      9:  return mk(2'b11, 3'd2, 3'b101, 3'b011, 9'd0);      // negative zero
      10: return mk(2'b11, 3'd1, 3'b011, 3'b101, 9'd511);    // -511
      11: return mk(2'b10, 3'd4, 3'b010, 3'b010, 9'd5);      // reserved op
      12: return mk(2'b00, 3'd4, 3'b001, 3'b111, 9'd511);    // branch -4094
      13: return mk(2'b01, 3'd5, 3'b000, 3'b000, 9'd3);      // bad condition
      14: return mk(2'b00, 3'd1, 3'b100, 3'b000, 9'd3);      // nonzero filler
      15: return mk(2'b11, 3'd7, 3'b000, 3'b010, 9'd9);      // indexed subroutine jump
      16: return mk(2'b10, 3'd6, 3'b000, 3'b000, 9'd300);    // plain jump
      17: return mk(2'b11, 3'd6, 3'b001, 3'b000, 9'd0);      // store-form target 0, byte 1
      18: return mk(2'b11, 3'd7, 3'b111, 3'b101, 9'd77);     // store variant
      19: return mk(2'b10, 3'd6, 3'b100, 3'b011, 9'd12);     // LEA
      20: return mk(2'b10, 3'd7, 3'b100, 3'b000, 9'd12);     // bad LEA variant
      21: return mk(2'b10, 3'd6, 3'b011, 3'b000, 9'd33);     // shift filler nonzero
      22: return mk(2'b01, 3'd6, 3'b001, 3'b000, 9'd0);      // set-always
      23: return mk(2'b00, 3'd7, 3'b001, 3'b000, 9'd1);      // malformed interrupt
      default: ;
    endcase
    case ($urandom % 8)
      0: return r;
      1: return {2'b00, r[17:15], 2'b00, r[12:0]};
      2: return {2'b01, r[17:15], 2'b00, r[12:0]};
      3: return {2'b10, 2'b11, r[15:13], 1'b1, r[11:10], 5'd0, 5'($urandom % 24)};
      4: return {1'b1, r[18:0]};
      5: return {2'b11, 2'b11, r[15:0]};
      6: return {2'b10, 2'b11, r[15:13], 1'b0, r[11:0]};
      default: return {2'b00, 3'b11, r[15], r[14:12] & 3'b001, 1'b0, r[10], 1'b0, 9'd0};
    endcase
  endfunction

  task automatic compare(input dec_t e, input string extra);
    dec_t a;
    a = {out_class, out_illegal, out_op, out_indexed, out_target, out_index,
         out_byte, out_flag, out_disp, out_shift_cnt, out_shift_mode};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s%s: actual=%h expected=%h", tag_of(e.cls), extra, a, e);
    end
  endtask

  dec_t q[$];

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; out_ready = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    #1;
    checks++;                                               // R13 during reset
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R13: actual valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    checks++;                                               // R13 after release
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R13: actual valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
    end
    begin
      int  k;
      bit  acc;
      k   = 0;
      acc = 1'b0;
      while (k < N_TOT || q.size() != 0 || (in_valid && !acc)) begin
        @(negedge clk);
        if (acc || !in_valid) begin
          if (k < N_TOT && ($urandom % 4) != 0) begin
            in_word  = gen(k);
            in_valid = 1'b1;
            k++;
          end else begin
            in_valid = 1'b0;
          end
        end
        out_ready = ($urandom % 3) != 0;
        #1;
        checks++;                                           // R12 one-cycle latency
        if (out_valid !== (q.size() != 0)) begin
          errors++;
          $display("FAIL R12: actual out_valid=%b expected %b", out_valid, q.size() != 0);
        end
        checks++;                                           // R12 ready rule
        if (in_ready !== (!out_valid || out_ready)) begin
          errors++;
          $display("FAIL R12: actual in_ready=%b expected %b", in_ready, !out_valid || out_ready);
        end
        if (out_valid && q.size() != 0) begin
          if (out_ready) begin
            compare(q[0], "");
            void'(q.pop_front());
          end else begin
            compare(q[0], " R12 held");
          end
        end
        acc = in_valid && in_ready;
        if (acc) q.push_back(ref_dec(in_word));
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R12: watchdog expired, actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule